// File: doc/BRIEF.md
# Paged Descriptor Ring Address Generator

This block holds the index state for three circular descriptor rings that live in host memory: a request ring the block consumes, a completion ring it fills, and an optional message ring it fills. None of the rings is one contiguous buffer. Each is spread over a small table of page numbers. On every pop the block masks a free-running pointer down to a ring slot. It splits that slot into a page-table index and an in-page index, and returns the byte address of the descriptor in the same cycle as the handshake.

All control arrives through one operation port that accepts a single operation per cycle. The operations are: load a page-table entry, set up the two data rings, set up the message ring, pop from one of the three rings, publish a pointer, and clean. The host's producer and consumer indices come in as plain inputs. Every index the block must publish to the shared state area leaves through a registered write-back port, one field per cycle. A ring setup emits a short burst of such writes, and the operation port is held off until that burst has drained.

The wrap mask comes from the bit length of (entry count − 1), with a minimum of one. The entry count is the page count times a per-ring entries-per-page parameter. Page numbers become byte addresses by a left shift of PAGE_SHIFT bits.

Top module: `pgring_addr_gen`

## Requirements
- R1: After reset, op_ready is 1 and wb_valid is 0. No ring is configured, so every pop (op_code 4, 5 or 6) is acknowledged with rsp_none = 1 and rsp_addr = 0.
- R2: A data-ring setup (op_code 2, request page count on op_pages_a, completion page count on op_pages_b) produces six writes on consecutive cycles, starting the cycle after acceptance. The wb_field codes are, in order, 0 (request producer), 1 (request consumer), 2 (request log2), 3 (completion producer), 4 (completion consumer), 5 (completion log2). The producer and consumer writes carry 0. Each log2 write carries the bit length, minimum 1, of (pages × entries-per-page − 1).
- R3: A successful pop returns (page_number[slot / EPP] << PAGE_SHIFT) + (slot mod EPP) × descriptor size, where slot = pointer & mask. The mask is (1 << log2) − 1.
- R4: Each ring pointer is free-running and advances by one per successful pop. After mask + 1 pops the returned address repeats.
- R5: A request pop (op_code 4) while host_req_prod equals the consumed pointer returns rsp_none = 1 and leaves the pointer unchanged.
- R6: A request publish (op_code 7) writes field 1 with the consumed pointer. A completion publish (op_code 8) writes field 3 with the fill pointer. Each write appears the cycle after acceptance.
- R7: A completion pop (op_code 5) on a configured ring always succeeds, with no overflow check, and wraps past the ring capacity.
- R8: A message pop (op_code 6) succeeds only when (host_msg_prod − host_msg_cons) modulo 2^IDX_W is at most the mask. On success, field 6 is written the next cycle with the advanced pointer. On failure it returns rsp_none = 1 and writes nothing.
- R9: A message-ring setup (op_code 3, page count on op_pages_a) is ignored unless the data rings are configured. When accepted, it writes fields 6, 7 and 8: two zeros, then the message log2.
- R10: Clean (op_code 9) zeroes all page tables, masks and pointers, marks every ring unconfigured, and writes nothing.
- R11: While a setup burst is still draining, op_ready is 0. It returns to 1 in the cycle that shows the burst's last write.
- R12: A setup zeroes the pointers of the rings it configures and keeps their page tables. A page load (op_code 1) writes op_pgnum into entry op_slot of the ring chosen by op_ring: 0 request, 1 completion, 2 message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation port free (no setup burst pending) |
| op_code | input | 4 | Operation code |
| op_ring | input | 2 | Ring select for page load |
| op_slot | input | SLOT_W (2) | Page-table entry for page load |
| op_pgnum | input | PGN_W (36) | Page number for page load |
| op_pages_a | input | NP_W (3) | Page count: request ring, or message ring |
| op_pages_b | input | NP_W (3) | Page count: completion ring |
| host_req_prod | input | IDX_W (32) | Host request producer index |
| host_msg_prod | input | IDX_W (32) | Message producer index from shared area |
| host_msg_cons | input | IDX_W (32) | Message consumer index from shared area |
| rsp_addr | output | ADDR_W (48) | Descriptor address of an accepted pop |
| rsp_none | output | 1 | Accepted pop found nothing (empty, full or unconfigured) |
| wb_valid | output | 1 | Write-back to shared state area |
| wb_field | output | 4 | Field code of the write-back |
| wb_data | output | IDX_W (32) | Value written back |

## Verification
The assertions watch what the port relation guarantees on every cycle. A data setup always opens with a zero write to field 0. A held-off port always means a write is on its way. A publish always writes its own field. Message pops write exactly when they succeed, while request pops and cleans write nothing. Only the scenarios can show the address arithmetic itself: page-table selection across a page boundary, wrap after mask + 1 pops, modular room in the message ring, the pointer held through an empty pop, and page tables that survive a re-setup but not a clean.

// File: rtl/pgring_pkg.sv
package pgring_pkg;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_LOAD_PAGE  = 4'd1,
    OP_SETUP_DATA = 4'd2,
    OP_SETUP_MSG  = 4'd3,
    OP_POP_REQ    = 4'd4,
    OP_PUSH_CMP   = 4'd5,
    OP_PUSH_MSG   = 4'd6,
    OP_FLUSH_REQ  = 4'd7,
    OP_FLUSH_CMP  = 4'd8,
    OP_CLEAN      = 4'd9
  } op_e;

  // Field codes of the shared state area, in the order a setup burst walks them.
  typedef enum logic [3:0] {
    F_REQ_PROD = 4'd0,
    F_REQ_CONS = 4'd1,
    F_REQ_LOG2 = 4'd2,
    F_CMP_PROD = 4'd3,
    F_CMP_CONS = 4'd4,
    F_CMP_LOG2 = 4'd5,
    F_MSG_PROD = 4'd6,
    F_MSG_CONS = 4'd7,
    F_MSG_LOG2 = 4'd8
  } field_e;

  localparam int NUM_RINGS = 3;

  // Number of significant bits of x, never less than one.
  function automatic logic [6:0] bit_len_min1(input logic [63:0] x);
    logic [6:0] n;
    n = 7'd1;
    for (int i = 0; i < 64; i++) begin
      if (x[i]) n = 7'(i + 1);
    end
    return n;
  endfunction

endpackage

// File: rtl/pgring_core.sv
module pgring_core
  import pgring_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int IDX_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int MAX_PAGES  = 4,
  parameter int EPP        = 32,
  parameter int DSZ        = 128,
  localparam int PGN_W  = ADDR_W - PAGE_SHIFT,
  localparam int SLOT_W = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
  localparam int NP_W   = $clog2(MAX_PAGES + 1),
  localparam int LOG_W  = $clog2(IDX_W + 1),
  localparam int EPP_SH = $clog2(EPP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clean_i,
  input  logic              pg_we_i,
  input  logic [SLOT_W-1:0] pg_slot_i,
  input  logic [PGN_W-1:0]  pg_num_i,
  input  logic              init_i,
  input  logic [NP_W-1:0]   npages_i,
  input  logic              adv_i,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [IDX_W-1:0]  mask_o,
  output logic [LOG_W-1:0]  log2_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [PGN_W-1:0]  tbl_rd [MAX_PAGES];
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic [IDX_W-1:0]  mask_q, mask_d, mask_new;
  logic [LOG_W-1:0]  log_q, log_d, log_new;
  logic [63:0]       last_idx;
  logic [6:0]        blen;
  logic              st_en;

  // Page table: one register per entry, each with its own write enable.
  for (genvar p = 0; p < MAX_PAGES; p++) begin : g_pg
    logic             ent_en;
    logic [PGN_W-1:0] ent_q, ent_d;

    assign ent_en = clean_i | (pg_we_i & (pg_slot_i == SLOT_W'(p)));
    assign ent_d  = clean_i ? '0 : pg_num_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign tbl_rd[p] = ent_q;
  end

  // Ring size: bit length of (entries - 1), clamped to the pointer width.
  always_comb begin
    last_idx = 64'(npages_i) * 64'(EPP) - 64'd1;
    blen     = bit_len_min1(last_idx);
    if (blen >= 7'(IDX_W)) begin
      log_new  = LOG_W'(IDX_W);
      mask_new = '1;
    end else begin
      log_new  = LOG_W'(blen);
      mask_new = (IDX_W'(1) << blen) - IDX_W'(1);
    end
  end

  always_comb begin
    ptr_d  = ptr_q;
    log_d  = log_q;
    mask_d = mask_q;
    if (clean_i) begin
      ptr_d  = '0;
      log_d  = '0;
      mask_d = '0;
    end else if (init_i) begin
      ptr_d  = '0;
      log_d  = log_new;
      mask_d = mask_new;
    end else if (adv_i) begin
      ptr_d  = ptr_q + IDX_W'(1);
    end
  end

  assign st_en = clean_i | init_i | adv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      log_q  <= '0;
      mask_q <= '0;
    end else if (st_en) begin
      ptr_q  <= ptr_d;
      log_q  <= log_d;
      mask_q <= mask_d;
    end
  end

  // Address: masked slot -> page-table index and in-page index.
  logic [IDX_W-1:0]  slot;
  logic [SLOT_W-1:0] page_sel;
  logic [EPP_SH-1:0] in_page;
  logic [ADDR_W-1:0] base, offs;

  assign slot     = ptr_q & mask_q;
  assign page_sel = SLOT_W'(slot >> EPP_SH);
  assign in_page  = EPP_SH'(slot);
  assign base     = {tbl_rd[page_sel], {PAGE_SHIFT{1'b0}}};
  assign offs     = ADDR_W'(in_page) * ADDR_W'(DSZ);
  assign addr_o   = base + offs;

  assign ptr_o  = ptr_q;
  assign mask_o = mask_q;
  assign log2_o = log_q;

endmodule

// File: rtl/pgring_addr_gen.sv
module pgring_addr_gen
  import pgring_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int IDX_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int MAX_PAGES  = 4,
  parameter int REQ_EPP    = 32,
  parameter int REQ_DSZ    = 128,
  parameter int CMP_EPP    = 128,
  parameter int CMP_DSZ    = 32,
  parameter int MSG_EPP    = 32,
  parameter int MSG_DSZ    = 128,
  localparam int PGN_W  = ADDR_W - PAGE_SHIFT,
  localparam int SLOT_W = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
  localparam int NP_W   = $clog2(MAX_PAGES + 1),
  localparam int LOG_W  = $clog2(IDX_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [3:0]        op_code,
  input  logic [1:0]        op_ring,
  input  logic [SLOT_W-1:0] op_slot,
  input  logic [PGN_W-1:0]  op_pgnum,
  input  logic [NP_W-1:0]   op_pages_a,
  input  logic [NP_W-1:0]   op_pages_b,
  input  logic [IDX_W-1:0]  host_req_prod,
  input  logic [IDX_W-1:0]  host_msg_prod,
  input  logic [IDX_W-1:0]  host_msg_cons,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_none,
  output logic              wb_valid,
  output logic [3:0]        wb_field,
  output logic [IDX_W-1:0]  wb_data
);

  localparam logic [2:0] DATA_BURST_LEFT = 3'd5;
  localparam logic [2:0] MSG_BURST_LEFT  = 3'd2;

  op_e  code;
  logic ack;
  logic is_load, is_setup_d, is_setup_m, is_pop_req, is_push_cmp, is_push_msg;
  logic is_flush_req, is_flush_cmp, is_clean;

  logic [NUM_RINGS-1:0] pg_we, init, adv;
  logic [NP_W-1:0]      np_sel [NUM_RINGS];
  logic [IDX_W-1:0]     ptr    [NUM_RINGS];
  logic [IDX_W-1:0]     mask   [NUM_RINGS];
  logic [LOG_W-1:0]     lg     [NUM_RINGS];
  logic [ADDR_W-1:0]    addr   [NUM_RINGS];

  logic data_ok_q, data_ok_d, msg_ok_q, msg_ok_d, flag_en;
  logic req_has, msg_room;

  logic [2:0]       seq_left_q, seq_left_d;
  logic [3:0]       seq_field_q, seq_field_d;
  logic             wb_valid_q, wb_valid_d;
  logic [3:0]       wb_field_q, wb_field_d;
  logic [IDX_W-1:0] wb_data_q, wb_data_d;
  logic [IDX_W-1:0] seq_value;

  // Operation decode
  assign code     = op_e'(op_code);
  assign op_ready = (seq_left_q == 3'd0);
  assign ack      = op_valid & op_ready;

  assign is_load      = ack && (code == OP_LOAD_PAGE);
  assign is_setup_d   = ack && (code == OP_SETUP_DATA);
  assign is_setup_m   = ack && (code == OP_SETUP_MSG);
  assign is_pop_req   = ack && (code == OP_POP_REQ);
  assign is_push_cmp  = ack && (code == OP_PUSH_CMP);
  assign is_push_msg  = ack && (code == OP_PUSH_MSG);
  assign is_flush_req = ack && (code == OP_FLUSH_REQ);
  assign is_flush_cmp = ack && (code == OP_FLUSH_CMP);
  assign is_clean     = ack && (code == OP_CLEAN);

  // Availability checks
  assign req_has  = data_ok_q && (host_req_prod != ptr[0]);
  assign msg_room = msg_ok_q && ((host_msg_prod - host_msg_cons) <= mask[2]);

  // Per-ring control
  always_comb begin
    for (int r = 0; r < NUM_RINGS; r++) begin
      pg_we[r] = is_load && (op_ring == 2'(r));
    end
    init[0]   = is_setup_d;
    init[1]   = is_setup_d;
    init[2]   = is_setup_m && data_ok_q;
    adv[0]    = is_pop_req && req_has;
    adv[1]    = is_push_cmp && data_ok_q;
    adv[2]    = is_push_msg && msg_room;
    np_sel[0] = op_pages_a;
    np_sel[1] = op_pages_b;
    np_sel[2] = op_pages_a;
  end

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    localparam int EPP = (r == 0) ? REQ_EPP : ((r == 1) ? CMP_EPP : MSG_EPP);
    localparam int DSZ = (r == 0) ? REQ_DSZ : ((r == 1) ? CMP_DSZ : MSG_DSZ);

    pgring_core #(
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .MAX_PAGES  (MAX_PAGES),
      .EPP        (EPP),
      .DSZ        (DSZ)
    ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .clean_i   (is_clean),
      .pg_we_i   (pg_we[r]),
      .pg_slot_i (op_slot),
      .pg_num_i  (op_pgnum),
      .init_i    (init[r]),
      .npages_i  (np_sel[r]),
      .adv_i     (adv[r]),
      .ptr_o     (ptr[r]),
      .mask_o    (mask[r]),
      .log2_o    (lg[r]),
      .addr_o    (addr[r])
    );
  end

  // Pop response, same cycle as acceptance
  always_comb begin
    rsp_none = 1'b0;
    rsp_addr = '0;
    if (is_pop_req) begin
      rsp_none = ~req_has;
      if (req_has) rsp_addr = addr[0];
    end else if (is_push_cmp) begin
      rsp_none = ~data_ok_q;
      if (data_ok_q) rsp_addr = addr[1];
    end else if (is_push_msg) begin
      rsp_none = ~msg_room;
      if (msg_room) rsp_addr = addr[2];
    end
  end

  // Configured flags
  always_comb begin
    data_ok_d = data_ok_q;
    msg_ok_d  = msg_ok_q;
    if (is_clean) begin
      data_ok_d = 1'b0;
      msg_ok_d  = 1'b0;
    end else if (is_setup_d) begin
      data_ok_d = 1'b1;
    end else if (is_setup_m && data_ok_q) begin
      msg_ok_d  = 1'b1;
    end
  end

  assign flag_en = is_clean | is_setup_d | is_setup_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ok_q <= 1'b0;
      msg_ok_q  <= 1'b0;
    end else if (flag_en) begin
      data_ok_q <= data_ok_d;
      msg_ok_q  <= msg_ok_d;
    end
  end

  // Write-back sequencer
  always_comb begin
    case (field_e'(seq_field_q))
      F_REQ_LOG2: seq_value = IDX_W'(lg[0]);
      F_CMP_LOG2: seq_value = IDX_W'(lg[1]);
      F_MSG_LOG2: seq_value = IDX_W'(lg[2]);
      default:    seq_value = '0;
    endcase
  end

  always_comb begin
    wb_valid_d  = 1'b0;
    wb_field_d  = wb_field_q;
    wb_data_d   = wb_data_q;
    seq_left_d  = seq_left_q;
    seq_field_d = seq_field_q;
    if (seq_left_q != 3'd0) begin
      wb_valid_d  = 1'b1;
      wb_field_d  = seq_field_q;
      wb_data_d   = seq_value;
      seq_left_d  = seq_left_q - 3'd1;
      seq_field_d = seq_field_q + 4'd1;
    end else if (is_setup_d) begin
      wb_valid_d  = 1'b1;
      wb_field_d  = F_REQ_PROD;
      wb_data_d   = '0;
      seq_left_d  = DATA_BURST_LEFT;
      seq_field_d = F_REQ_CONS;
    end else if (is_setup_m && data_ok_q) begin
      wb_valid_d  = 1'b1;
      wb_field_d  = F_MSG_PROD;
      wb_data_d   = '0;
      seq_left_d  = MSG_BURST_LEFT;
      seq_field_d = F_MSG_CONS;
    end else if (is_flush_req) begin
      wb_valid_d  = 1'b1;
      wb_field_d  = F_REQ_CONS;
      wb_data_d   = ptr[0];
    end else if (is_flush_cmp) begin
      wb_valid_d  = 1'b1;
      wb_field_d  = F_CMP_PROD;
      wb_data_d   = ptr[1];
    end else if (is_push_msg && msg_room) begin
      wb_valid_d  = 1'b1;
      wb_field_d  = F_MSG_PROD;
      wb_data_d   = ptr[2] + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid_q  <= 1'b0;
      seq_left_q  <= '0;
      seq_field_q <= '0;
    end else begin
      wb_valid_q  <= wb_valid_d;
      seq_left_q  <= seq_left_d;
      seq_field_q <= seq_field_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_field_q <= '0;
      wb_data_q  <= '0;
    end else if (wb_valid_d) begin
      wb_field_q <= wb_field_d;
      wb_data_q  <= wb_data_d;
    end
  end

  assign wb_valid = wb_valid_q;
  assign wb_field = wb_field_q;
  assign wb_data  = wb_data_q;

endmodule

// File: rtl/pgring_addr_gen_chk.sv
module pgring_addr_gen_chk #(
  parameter int IDX_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic [3:0]       op_code,
  input logic             rsp_none,
  input logic             wb_valid,
  input logic [3:0]       wb_field,
  input logic [IDX_W-1:0] wb_data
);

  logic ack;
  assign ack = op_valid && op_ready;

  AST_SETUP_OPENS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ack && op_code == 4'd2 |=> wb_valid && wb_field == 4'd0 && wb_data == '0); // R2

  AST_FIELD_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_field <= 4'd8); // R2

  AST_POP_REQ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ack && op_code == 4'd4 |=> !wb_valid); // R5

  AST_FLUSH_REQ_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    ack && op_code == 4'd7 |=> wb_valid && wb_field == 4'd1); // R6

  AST_FLUSH_CMP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    ack && op_code == 4'd8 |=> wb_valid && wb_field == 4'd3); // R6

  AST_MSG_FULL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ack && op_code == 4'd6 && rsp_none |=> !wb_valid); // R8

  AST_MSG_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
    ack && op_code == 4'd6 && !rsp_none |=> wb_valid && wb_field == 4'd6); // R8

  AST_CLEAN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ack && op_code == 4'd9 |=> !wb_valid); // R10

  AST_BUSY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |=> wb_valid); // R11

endmodule

bind pgring_addr_gen pgring_addr_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_code  (op_code),
  .rsp_none (rsp_none),
  .wb_valid (wb_valid),
  .wb_field (wb_field),
  .wb_data  (wb_data)
);

// File: tb/pgring_addr_gen_bench.sv
module pgring_addr_gen_bench;
  import pgring_pkg::*;

  localparam int ADDR_W = 48;
  localparam int IDX_W  = 32;
  localparam int SLOT_W = 2;
  localparam int PGN_W  = 36;
  localparam int NP_W   = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              op_valid;
  logic              op_ready;
  logic [3:0]        op_code;
  logic [1:0]        op_ring;
  logic [SLOT_W-1:0] op_slot;
  logic [PGN_W-1:0]  op_pgnum;
  logic [NP_W-1:0]   op_pages_a, op_pages_b;
  logic [IDX_W-1:0]  host_req_prod, host_msg_prod, host_msg_cons;
  logic [ADDR_W-1:0] rsp_addr;
  logic              rsp_none;
  logic              wb_valid;
  logic [3:0]        wb_field;
  logic [IDX_W-1:0]  wb_data;

  pgring_addr_gen u_pgring_addr_gen (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_ring(op_ring), .op_slot(op_slot), .op_pgnum(op_pgnum),
    .op_pages_a(op_pages_a), .op_pages_b(op_pages_b),
    .host_req_prod(host_req_prod), .host_msg_prod(host_msg_prod),
    .host_msg_cons(host_msg_cons), .rsp_addr(rsp_addr), .rsp_none(rsp_none),
    .wb_valid(wb_valid), .wb_field(wb_field), .wb_data(wb_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic              cap_none, cap_wbv, cap_rdy;
  logic [ADDR_W-1:0] cap_addr;
  logic [3:0]        cap_wbf;
  logic [IDX_W-1:0]  cap_wbd;

  // {pop number, expected request descriptor address}
  localparam logic [63:0] REQ_VEC [0:5] = '{
    {16'd0,  48'h0000_0010_0000},
    {16'd1,  48'h0000_0010_0080},
    {16'd31, 48'h0000_0010_0F80},
    {16'd32, 48'h0000_002A_0000},
    {16'd63, 48'h0000_002A_0F80},
    {16'd64, 48'h0000_0010_0000}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input op_e code, input logic [1:0] ring, input logic [SLOT_W-1:0] slot,
                       input logic [PGN_W-1:0] pg, input logic [NP_W-1:0] pa,
                       input logic [NP_W-1:0] pb);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_ring = ring; op_slot = slot;
    op_pgnum = pg; op_pages_a = pa; op_pages_b = pb;
    #1;
    cap_none = rsp_none;
    cap_addr = rsp_addr;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    cap_wbv = wb_valid; cap_wbf = wb_field; cap_wbd = wb_data; cap_rdy = op_ready;
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
    cap_wbv = wb_valid; cap_wbf = wb_field; cap_wbd = wb_data; cap_rdy = op_ready;
  endtask

  task automatic pop(input op_e code);
    issue(code, 2'd0, '0, '0, '0, '0);
  endtask

  task automatic setup_data(input string req, input logic [31:0] lg_req,
                            input logic [31:0] lg_cmp);
    logic [31:0] exp_d [0:5];
    exp_d = '{32'd0, 32'd0, lg_req, 32'd0, 32'd0, lg_cmp};
    issue(OP_SETUP_DATA, 2'd0, '0, '0, 3'd2, 3'd1);
    check(req, "setup write 0 valid", 64'(cap_wbv), 64'd1);
    check(req, "setup write 0 field", 64'(cap_wbf), 64'd0);
    check("R11", "ready low in burst", 64'(cap_rdy), 64'd0);
    for (int k = 1; k < 6; k++) begin
      next_cycle();
      check(req, "setup write field", 64'(cap_wbf), 64'(k));
      check(req, "setup write data", 64'(cap_wbd), 64'(exp_d[k]));
    end
    check("R11", "ready back after burst", 64'(cap_rdy), 64'd1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int popped;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_ring = '0; op_slot = '0;
    op_pgnum = '0; op_pages_a = '0; op_pages_b = '0;
    host_req_prod = 32'd1000; host_msg_prod = '0; host_msg_cons = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: reset state
    check("R1", "ready after reset", 64'(op_ready), 64'd1);
    check("R1", "no write after reset", 64'(wb_valid), 64'd0);
    pop(OP_POP_REQ);
    check("R1", "request pop unconfigured", 64'(cap_none), 64'd1);
    check("R1", "request pop address", 64'(cap_addr), 64'd0);
    pop(OP_PUSH_CMP);
    check("R1", "completion pop unconfigured", 64'(cap_none), 64'd1);

    // R9: message setup ignored before data rings
    issue(OP_LOAD_PAGE, 2'd2, 2'd0, 36'h400, '0, '0);
    issue(OP_SETUP_MSG, 2'd0, '0, '0, 3'd1, 3'd0);
    check("R9", "early msg setup writes nothing", 64'(cap_wbv), 64'd0);
    host_msg_prod = 32'd1;
    pop(OP_PUSH_MSG);
    check("R9", "msg pop after ignored setup", 64'(cap_none), 64'd1);

    // R12: page loads, then data setup (R2)
    issue(OP_LOAD_PAGE, 2'd0, 2'd0, 36'h100, '0, '0);
    issue(OP_LOAD_PAGE, 2'd0, 2'd1, 36'h2A0, '0, '0);
    issue(OP_LOAD_PAGE, 2'd1, 2'd0, 36'h300, '0, '0);
    setup_data("R2", 32'd6, 32'd7);

    // R3 / R4: vector walk over the request ring
    popped = 0;
    for (int v = 0; v < 6; v++) begin
      while (popped < int'(REQ_VEC[v][63:48])) begin
        pop(OP_POP_REQ);
        popped++;
      end
      pop(OP_POP_REQ);
      popped++;
      check("R3", "request pop present", 64'(cap_none), 64'd0);
      check(v == 5 ? "R4" : "R3", "request address", 64'(cap_addr), 64'(REQ_VEC[v][47:0]));
    end

    // R6: publish consumer index
    issue(OP_FLUSH_REQ, 2'd0, '0, '0, '0, '0);
    check("R6", "req publish valid", 64'(cap_wbv), 64'd1);
    check("R6", "req publish field", 64'(cap_wbf), 64'd1);
    check("R6", "req publish data", 64'(cap_wbd), 64'd65);

    // R5: empty ring
    host_req_prod = 32'd65;
    pop(OP_POP_REQ);
    check("R5", "pop on empty", 64'(cap_none), 64'd1);
    issue(OP_FLUSH_REQ, 2'd0, '0, '0, '0, '0);
    check("R5", "pointer held on empty", 64'(cap_wbd), 64'd65);
    host_req_prod = 32'd66;
    pop(OP_POP_REQ);
    check("R4", "pop after refill", 64'(cap_addr), 64'h10_0080);

    // R7: completion ring wraps with no overflow check
    for (int c = 0; c < 129; c++) begin
      pop(OP_PUSH_CMP);
      if (c == 0)   check("R7", "cmp first", 64'(cap_addr), 64'h30_0000);
      if (c == 1)   check("R7", "cmp second", 64'(cap_addr), 64'h30_0020);
      if (c == 127) check("R7", "cmp last slot", 64'(cap_addr), 64'h30_0FE0);
      if (c == 128) begin
        check("R7", "cmp over capacity present", 64'(cap_none), 64'd0);
        check("R7", "cmp wrapped", 64'(cap_addr), 64'h30_0000);
      end
    end
    issue(OP_FLUSH_CMP, 2'd0, '0, '0, '0, '0);
    check("R6", "cmp publish field", 64'(cap_wbf), 64'd3);
    check("R6", "cmp publish data", 64'(cap_wbd), 64'd129);

    // R9: message setup after data rings
    issue(OP_SETUP_MSG, 2'd0, '0, '0, 3'd1, 3'd0);
    check("R9", "msg setup field 6", 64'(cap_wbf), 64'd6);
    next_cycle();
    check("R9", "msg setup field 7", 64'(cap_wbf), 64'd7);
    next_cycle();
    check("R9", "msg setup field 8", 64'(cap_wbf), 64'd8);
    check("R9", "msg log2", 64'(cap_wbd), 64'd5);

    // R8: message room
    host_msg_prod = 32'd31; host_msg_cons = 32'd0;
    pop(OP_PUSH_MSG);
    check("R8", "msg room at mask", 64'(cap_addr), 64'h40_0000);
    check("R8", "msg publish data", 64'(cap_wbd), 64'd1);
    host_msg_prod = 32'd2; host_msg_cons = 32'hFFFF_FFF0;
    pop(OP_PUSH_MSG);
    check("R8", "msg modular room", 64'(cap_addr), 64'h40_0080);
    check("R8", "msg publish second", 64'(cap_wbd), 64'd2);
    host_msg_prod = 32'd32; host_msg_cons = 32'd0;
    pop(OP_PUSH_MSG);
    check("R8", "msg full", 64'(cap_none), 64'd1);
    check("R8", "msg full no write", 64'(cap_wbv), 64'd0);
    host_msg_prod = 32'd5; host_msg_cons = 32'hFFFF_FF00;
    pop(OP_PUSH_MSG);
    check("R8", "msg modular full", 64'(cap_none), 64'd1);

    // R12: re-setup keeps tables, zeroes pointers
    setup_data("R12", 32'd6, 32'd7);
    pop(OP_POP_REQ);
    check("R12", "pointer restarts", 64'(cap_addr), 64'h10_0000);

    // R10: clean
    issue(OP_CLEAN, 2'd0, '0, '0, '0, '0);
    check("R10", "clean writes nothing", 64'(cap_wbv), 64'd0);
    pop(OP_POP_REQ);
    check("R10", "request unconfigured after clean", 64'(cap_none), 64'd1);
    host_msg_prod = 32'd1; host_msg_cons = 32'd0;
    pop(OP_PUSH_MSG);
    check("R10", "msg unconfigured after clean", 64'(cap_none), 64'd1);
    setup_data("R10", 32'd6, 32'd7);
    pop(OP_POP_REQ);
    check("R10", "table zeroed slot 0", 64'(cap_addr), 64'h0);
    pop(OP_POP_REQ);
    check("R10", "table zeroed slot 1", 64'(cap_addr), 64'h80);

    done = 1'b1;
    finish_run();
  end

endmodule